// File: doc/BRIEF.md
# Shortened Reed-Solomon Encoder

This block is a systematic Reed-Solomon encoder over GF(2^8). Each codeword carries 16 check bytes, so a decoder can repair up to 8 corrupted bytes. Message bytes enter on a valid/ready byte stream. The encoder copies each message byte to its output unchanged. After the last message byte it emits the 16 check bytes. The codeword length n is chosen at run time from 50 to 255. A shorter codeword behaves like the full 255-byte code whose leading message bytes are all zero.

An upstream source streams the message with `in_valid` held high. After the final message byte, `in_ready` drops for exactly 16 cycles while the check bytes leave the block. Because of this, a source that keeps `in_valid` high produces an output stream with no gaps, one byte per clock. The length and the bypass selection are captured together with the first byte of each codeword. Firmware can therefore change them for the next codeword while the current one is still being encoded. In bypass, bytes pass straight through with no check bytes and no codeword framing.

Top module: `rs_shortened_enc`

## Requirements
- R1: In coded mode, the first n-16 output bytes of a codeword are the accepted message bytes, unchanged and in order. The 16 check bytes follow them.
- R2: Arithmetic uses the field polynomial x^8+x^4+x^3+x^2+1 with alpha = 0x02. Read the codeword as a polynomial with its first output byte as the highest-degree coefficient. This polynomial is zero at alpha^0 through alpha^15. An all-zero message therefore gives all-zero check bytes.
- R3: A codeword has exactly n output bytes, where n is the value of `cfg_len`. Values of `cfg_len` below 50 are treated as 50, so the message length is n-16.
- R4: `cfg_len` and `cfg_bypass` are captured only when the first byte of a codeword is accepted. Changes made later in the same codeword have no effect on that codeword.
- R5: A byte accepted at a rising edge is presented on `out_data`, with `out_valid` high, two rising edges later. This holds for coded and bypass bytes alike.
- R6: `in_ready` stays high while message bytes are accepted. It goes low for exactly 16 consecutive cycles right after the final message byte is accepted. With continuous input, the output carries one byte per cycle with no gaps, including across codeword boundaries.
- R7: `out_last` is high together with the 16th check byte of each codeword, and at no other time.
- R8: When bypass is captured, `in_ready` stays high and every byte appears unchanged with the R5 latency. No check bytes are added and `out_last` stays low.
- R9: While `rst_n` is low, `out_valid` and `out_last` are low, `in_ready` is high and the check-byte state is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_len | input | 8 | Codeword length n (50..255; lower values are clamped) |
| cfg_bypass | input | 1 | 1 = pass bytes through without coding |
| in_valid | input | 1 | Input byte is valid |
| in_ready | output | 1 | Encoder can accept a byte this cycle |
| in_data | input | 8 | Input message byte |
| out_valid | output | 1 | Output byte is valid |
| out_data | output | 8 | Message byte or check byte |
| out_last | output | 1 | Marks the final check byte of a codeword |

## Verification
Several properties are checked on every cycle:
- the two-cycle path from an accepted byte to the output,
- the exact 16-cycle length of every input stall,
- that `out_last` never appears without `out_valid`,
- a lower bound on the codeword length,
- that bypass never stalls the input.

Other behaviours can only be shown by the bench scenarios: the correctness of the check bytes (shown through zero syndromes at all sixteen roots), the exact codeword length for every n, and that a change of length or bypass in mid-codeword is ignored. The bench sweeps every legal n and some clamped ones. It also covers back-to-back codewords of different lengths and transitions between bypass and coded mode.

// File: rtl/rs_enc_pkg.sv
package rs_enc_pkg;
  localparam int SYM_W = 8;
  localparam logic [SYM_W:0] FIELD_POLY = 9'h11D;

  typedef logic [SYM_W-1:0] sym_t;

  // GF(2^8) product, shift-and-add with reduction by FIELD_POLY
  function automatic sym_t gf_mul(sym_t a, sym_t b);
    sym_t acc;
    sym_t x;
    acc = '0;
    x = a;
    for (int i = 0; i < SYM_W; i++) begin
      if (b[i]) acc = acc ^ x;
      x = x[SYM_W-1] ? ((x << 1) ^ FIELD_POLY[SYM_W-1:0]) : (x << 1);
    end
    return acc;
  endfunction
endpackage

// File: rtl/rs_enc_ctrl.sv
module rs_enc_ctrl
  import rs_enc_pkg::*;
#(
  parameter int NPAR  = 16,
  parameter int N_MIN = 50,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_bypass,
  output logic             in_ready,
  output logic             accept,
  output logic             cw_start,
  output logic             feed,
  output logic             par_phase,
  output logic             par_final
);
  localparam int PCNT_W = $clog2(NPAR);
  localparam int K_MIN  = N_MIN - NPAR;

  logic [LEN_W-1:0]  cnt;
  logic [LEN_W-1:0]  k_q;
  logic              byp_q;
  logic [PCNT_W-1:0] pcnt;
  logic [LEN_W-1:0]  n_eff;
  logic [LEN_W-1:0]  k_new;
  logic [LEN_W-1:0]  cur_k;
  logic              cur_byp;
  logic              msg_last;

  always_comb begin
    in_ready  = !par_phase;
    accept    = in_valid && in_ready;
    cw_start  = accept && (cnt == '0);
    n_eff     = (cfg_len < LEN_W'(N_MIN)) ? LEN_W'(N_MIN) : cfg_len;
    k_new     = n_eff - LEN_W'(NPAR);
    cur_k     = cw_start ? k_new : k_q;
    cur_byp   = cw_start ? cfg_bypass : byp_q;
    feed      = accept && !cur_byp;
    msg_last  = feed && (cnt == cur_k - 1'b1);
    par_final = par_phase && (pcnt == PCNT_W'(NPAR - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt       <= '0;
      k_q       <= LEN_W'(K_MIN);
      byp_q     <= 1'b0;
      par_phase <= 1'b0;
      pcnt      <= '0;
    end else begin
      if (cw_start) begin
        k_q   <= k_new;
        byp_q <= cfg_bypass;
      end
      if (feed) cnt <= msg_last ? '0 : cnt + 1'b1;
      if (msg_last) begin
        par_phase <= 1'b1;
        pcnt      <= '0;
      end else if (par_phase) begin
        pcnt <= pcnt + 1'b1;
        if (par_final) par_phase <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rs_enc_lfsr.sv
module rs_enc_lfsr
  import rs_enc_pkg::*;
#(
  parameter int NPAR = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic feed,
  input  logic shift,
  input  sym_t din,
  output sym_t par_top
);
  // generator g(x) = prod_{i<NPAR} (x + alpha^i); leading 1 implicit
  function automatic logic [NPAR-1:0][SYM_W-1:0] gen_poly();
    logic [NPAR:0][SYM_W-1:0] g;
    sym_t root;
    g    = '0;
    g[0] = 8'h01;
    root = 8'h01;
    for (int i = 0; i < NPAR; i++) begin
      for (int j = NPAR; j > 0; j--) g[j] = g[j-1] ^ gf_mul(g[j], root);
      g[0] = gf_mul(g[0], root);
      root = gf_mul(root, 8'h02);
    end
    return g[NPAR-1:0];
  endfunction

  localparam logic [NPAR-1:0][SYM_W-1:0] GEN = gen_poly();

  logic [NPAR-1:0][SYM_W-1:0] par_q;
  logic [NPAR-1:0][SYM_W-1:0] par_d;
  sym_t fb;

  assign fb = din ^ par_q[NPAR-1];

  for (genvar j = 0; j < NPAR; j++) begin : g_stage
    sym_t prev;
    if (j == 0) begin : g_head
      assign prev = '0;
    end else begin : g_tail
      assign prev = par_q[j-1];
    end
    assign par_d[j] = feed ? (prev ^ gf_mul(fb, GEN[j])) : prev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) par_q <= '0;
    else if (feed || shift) par_q <= par_d;
  end

  assign par_top = par_q[NPAR-1];
endmodule

// File: rtl/rs_enc_pipe.sv
module rs_enc_pipe
  import rs_enc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept,
  input  logic par_phase,
  input  logic par_final,
  input  sym_t in_data,
  input  sym_t par_top,
  output logic out_valid,
  output sym_t out_data,
  output logic out_last
);
  logic s1_valid;
  sym_t s1_data;
  logic s1_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid  <= 1'b0;
      s1_data   <= '0;
      s1_last   <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      out_last  <= 1'b0;
    end else begin
      s1_valid  <= accept || par_phase;
      s1_data   <= par_phase ? par_top : in_data;
      s1_last   <= par_final;
      out_valid <= s1_valid;
      out_data  <= s1_data;
      out_last  <= s1_last;
    end
  end
endmodule

// File: rtl/rs_shortened_enc.sv
module rs_shortened_enc
  import rs_enc_pkg::*;
#(
  parameter int NPAR  = 16,
  parameter int N_MIN = 50,
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_bypass,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [SYM_W-1:0] in_data,
  output logic             out_valid,
  output logic [SYM_W-1:0] out_data,
  output logic             out_last
);
  logic accept;
  logic cw_start;
  logic feed;
  logic par_phase;
  logic par_final;
  sym_t par_top;

  rs_enc_ctrl #(.NPAR(NPAR), .N_MIN(N_MIN), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cfg_len(cfg_len),
    .cfg_bypass(cfg_bypass), .in_ready(in_ready), .accept(accept),
    .cw_start(cw_start), .feed(feed), .par_phase(par_phase),
    .par_final(par_final)
  );

  rs_enc_lfsr #(.NPAR(NPAR)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .feed(feed), .shift(par_phase),
    .din(in_data), .par_top(par_top)
  );

  rs_enc_pipe u_pipe (
    .clk(clk), .rst_n(rst_n), .accept(accept), .par_phase(par_phase),
    .par_final(par_final), .in_data(in_data), .par_top(par_top),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );
endmodule

// File: rtl/rs_enc_checker.sv
module rs_enc_checker #(
  parameter int NPAR  = 16,
  parameter int N_MIN = 50
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       out_valid,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       cw_start,
  input logic       cfg_bypass
);
  int lo_run;
  int out_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_run  <= 0;
      out_run <= 0;
    end else begin
      lo_run <= in_ready ? 0 : lo_run + 1;
      if (out_valid) out_run <= out_last ? 0 : out_run + 1;
    end
  end

  p_lat_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |-> ##2 (out_valid && out_data == $past(in_data, 2)));

  p_stall_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> lo_run < NPAR);

  p_stall_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ready) |-> lo_run == NPAR);

  p_last_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_valid);

  p_cw_min_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_last |-> out_run >= N_MIN - 1);

  p_bypass_nostall_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cw_start && cfg_bypass) |=> in_ready);

  always @(posedge clk) begin
    if (!rst_n) p_reset_idle_r9: assert (!out_valid && !out_last && in_ready);
  end
endmodule

bind rs_shortened_enc rs_enc_checker #(.NPAR(NPAR), .N_MIN(N_MIN)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
  .out_last(out_last), .cw_start(cw_start), .cfg_bypass(cfg_bypass)
);

// File: tb/rs_shortened_enc_test.sv
`timescale 1ns/1ps
module rs_shortened_enc_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_len = 8'd50;
  logic       cfg_bypass = 1'b0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_ready;
  logic       out_valid;
  logic [7:0] out_data;
  logic       out_last;

  rs_shortened_enc uut (
    .clk(clk), .rst_n(rst_n), .cfg_len(cfg_len), .cfg_bypass(cfg_bypass),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int wp = 0;
  int lo_cnt = 0;
  int mp = 0;
  int first_cyc = 0;
  bit first_seen = 0;
  int unsigned seed = 32'h1234_5678;
  logic [7:0] cap [0:1023];
  bit         capl [0:1023];
  int         capc [0:1023];
  logic [7:0] msg [0:1023];
  int gexp [0:254];
  int glog [0:255];

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid) begin
        cap[wp]  = out_data;
        capl[wp] = out_last;
        capc[wp] = cyc;
        wp = wp + 1;
      end
      if (!in_ready) lo_cnt = lo_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int gmul(int a, int b);
    if (a == 0 || b == 0) return 0;
    return gexp[(glog[a] + glog[b]) % 255];
  endfunction

  function automatic logic [7:0] mkb(int pat, int j);
    case (pat)
      0: return j[7:0];
      1: return 8'h00;
      2: return 8'hFF;
      default: begin
        seed = seed * 32'd1103515245 + 32'd12345;
        return seed[23:16];
      end
    endcase
  endfunction

  task automatic push(input logic [7:0] b);
    in_data  = b;
    in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    if (!first_seen) begin
      first_cyc  = cyc;
      first_seen = 1;
    end
    @(negedge clk);
  endtask

  task automatic clear_cap();
    wp = 0; lo_cnt = 0; mp = 0; first_seen = 0;
  endtask

  task automatic drain();
    in_valid = 1'b0;
    repeat (24) @(negedge clk);
  endtask

  task automatic send_cw(input int ncfg, input int pat, input int chg_at,
                         input int chg_len, input bit chg_byp);
    int ne;
    logic [7:0] b;
    cfg_len    = ncfg[7:0];
    cfg_bypass = 1'b0;
    ne = (ncfg < 50) ? 50 : ncfg;
    for (int j = 0; j < ne - 16; j++) begin
      if (j == chg_at) begin
        cfg_len    = chg_len[7:0];
        cfg_bypass = chg_byp;
      end
      b = mkb(pat, j);
      msg[mp + j] = b;
      push(b);
    end
    mp = mp + ne - 16;
  endtask

  task automatic check_cw(input int o, input int ne, input int mo);
    int mism;
    int nbad;
    int nl;
    int s;
    mism = 0;
    for (int j = 0; j < ne - 16; j++) if (cap[o + j] !== msg[mo + j]) mism++;
    chk(mism == 0, "R1", "message bytes altered", mism, 0);
    nbad = 0;
    for (int i = 0; i < 16; i++) begin
      s = 0;
      for (int j = 0; j < ne; j++) s = gmul(s, gexp[i]) ^ int'(cap[o + j]);
      if (s != 0) nbad++;
    end
    chk(nbad == 0, "R2", "nonzero syndromes", nbad, 0);
    nl = 0;
    for (int j = 0; j < ne; j++) if (capl[o + j]) nl++;
    chk(nl == 1 && capl[o + ne - 1], "R7", "last flag count", nl, 1);
  endtask

  initial begin
    int nz;
    gexp[0] = 1;
    glog[0] = 0;
    glog[1] = 0;
    for (int i = 1; i < 255; i++) begin
      int v;
      v = gexp[i-1] << 1;
      if (v >= 256) v = v ^ 'h11D;
      gexp[i] = v;
      glog[v] = i;
    end

    // R9: reset state
    repeat (5) @(negedge clk);
    chk(out_valid == 1'b0 && out_last == 1'b0, "R9", "outputs in reset", int'(out_valid), 0);
    chk(in_ready == 1'b1, "R9", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0, "R9", "out_valid after reset", int'(out_valid), 0);

    // sweep of every legal length: R1 R2 R3 R5 R6 R7
    for (int n = 50; n <= 255; n++) begin
      clear_cap();
      send_cw(n, n % 4, -1, 0, 1'b0);
      drain();
      chk(wp == n, "R3", "codeword length", wp, n);
      check_cw(0, n, 0);
      chk(lo_cnt == 16, "R6", "stall cycles", lo_cnt, 16);
      chk(capc[wp-1] - capc[0] == n - 1, "R6", "output span", capc[wp-1] - capc[0], n - 1);
      chk(capc[0] - first_cyc == 2, "R5", "latency", capc[0] - first_cyc, 2);
    end

    // R3: clamping of short lengths
    for (int t = 0; t < 3; t++) begin
      int nc;
      nc = (t == 0) ? 0 : (t == 1) ? 17 : 49;
      clear_cap();
      send_cw(nc, 3, -1, 0, 1'b0);
      drain();
      chk(wp == 50, "R3", "clamped length", wp, 50);
      check_cw(0, 50, 0);
    end

    // R4: length and bypass changed mid-codeword are ignored
    clear_cap();
    send_cw(60, 3, 5, 200, 1'b1);
    drain();
    chk(wp == 60, "R4", "length after mid change", wp, 60);
    chk(lo_cnt == 16, "R4", "still coded after bypass change", lo_cnt, 16);
    check_cw(0, 60, 0);

    // R6: back-to-back codewords of different lengths
    clear_cap();
    send_cw(50, 3, -1, 0, 1'b0);
    send_cw(70, 0, -1, 0, 1'b0);
    send_cw(255, 3, -1, 0, 1'b0);
    drain();
    chk(wp == 375, "R6", "back-to-back total", wp, 375);
    check_cw(0, 50, 0);
    check_cw(50, 70, 34);
    check_cw(120, 255, 88);
    chk(capc[wp-1] - capc[0] == 374, "R6", "back-to-back gapless", capc[wp-1] - capc[0], 374);
    chk(lo_cnt == 48, "R6", "back-to-back stalls", lo_cnt, 48);

    // R2: zero message yields zero check bytes
    clear_cap();
    send_cw(80, 1, -1, 0, 1'b0);
    drain();
    nz = 0;
    for (int j = 64; j < 80; j++) if (cap[j] != 8'h00) nz++;
    chk(nz == 0, "R2", "zero-message check bytes", nz, 0);

    // R8: bypass
    clear_cap();
    cfg_bypass = 1'b1;
    for (int j = 0; j < 40; j++) begin
      msg[j] = 8'(j * 7 + 3);
      push(msg[j]);
    end
    drain();
    chk(wp == 40, "R8", "bypass byte count", wp, 40);
    nz = 0;
    for (int j = 0; j < 40; j++) if (cap[j] !== msg[j] || capl[j]) nz++;
    chk(nz == 0, "R8", "bypass data or last", nz, 0);
    chk(lo_cnt == 0, "R8", "bypass stalls", lo_cnt, 0);
    chk(capc[0] - first_cyc == 2, "R5", "bypass latency", capc[0] - first_cyc, 2);

    // R8 then R4: bypass bytes followed directly by a coded codeword
    clear_cap();
    cfg_bypass = 1'b1;
    for (int j = 0; j < 3; j++) push(8'hA0 + 8'(j));
    send_cw(50, 2, -1, 0, 1'b0);
    drain();
    chk(wp == 53, "R8", "bypass then coded count", wp, 53);
    chk(cap[0] == 8'hA0 && cap[2] == 8'hA2, "R8", "bypass bytes", int'(cap[2]), 'hA2);
    check_cw(3, 50, 0);
    chk(capc[wp-1] - capc[0] == 52, "R6", "mixed gapless", capc[wp-1] - capc[0], 52);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R6 watchdog: actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule